// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block sits between the oscillator pad of a small 8-bit microcontroller and the rest of the core. It runs on the oscillator clock. A toggle flop divides that clock by two, which makes the internal clock independent of the input duty cycle. The divided clock is published as a one-cycle enable, `int_tick`, and six ticks make one machine cycle. The block also qualifies the raw reset pin. The pin must stay high for two machine cycles before the internal reset is asserted, and the reset then lasts for as long as the pin stays high.

The CPU writes two request bits that select the power mode. In idle, the CPU clock is stopped while the peripherals and the RAM keep running. Idle ends on an enabled interrupt or on a reset. In power-down, the oscillator is switched off and everything stops. Only the reset pin can leave power-down. A reset taken from power-down is marked with `ram_keep`, which tells the RAM that its retained contents must survive while the registers are re-initialised. The register-reset strobe `sfr_rst` is a separate signal and fires the same way for every reset.

When the reset pin rises during idle, the CPU clock is restarted at once. RAM writes stay blocked until the reset is qualified. Port writes are not gated by this block.

Top module: `pwr_clk_ctl`

## Requirements
- R1: After `pwr_on_n` is released, `cpu_clk_en`, `per_clk_en`, `osc_run` and `ram_wr_en` are high, and `sys_rst`, `sfr_rst` and `ram_keep` are low. While the oscillator runs, `int_tick` is high on every second oscillator cycle.
- R2: A reset-pin pulse of 22 oscillator cycles or fewer never asserts `sys_rst`. A pulse of 26 cycles or more always asserts it. In run mode, `sys_rst` rises between 22 and 30 cycles after the pin rises. From power-down, the bound is 34 cycles.
- R3: Once asserted, `sys_rst` stays high while the pin stays high. It falls within 6 oscillator cycles after the pin falls, and only at an edge where `int_tick` was high.
- R4: An idle request (`idle_req` high across a tick) taken in run mode drives `cpu_clk_en` low. `per_clk_en`, `osc_run` and `ram_wr_en` stay high.
- R5: Idle is left for run when `irq_pend` is high at a tick. Without an interrupt or the reset pin, idle holds.
- R6: A power-down request drives `osc_run`, `per_clk_en`, `cpu_clk_en` and `ram_wr_en` low, and `int_tick` stays low. If both requests are present at the same tick, power-down is taken.
- R7: In power-down, `irq_pend`, `idle_req` and `pd_req` have no effect. A reset-pin pulse of 22 cycles or fewer returns the block to power-down with no reset.
- R8: `ram_keep` rises on entry to power-down and stays high through the whole reset that ends it. It is low throughout a reset taken from run or from idle.
- R9: For every reset, whatever the mode it came from, `sfr_rst` is high for exactly one oscillator cycle, namely the first cycle in which `sys_rst` is high.
- R10: In idle, a high reset pin brings `cpu_clk_en` back within 3 cycles and holds `ram_wr_en` low until `sys_rst` rises. That window lasts 18 to 28 cycles. A short pin pulse returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| pwr_on_n | input | 1 | Asynchronous power-good, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| idle_req | input | 1 | Idle request bit written by the CPU |
| pd_req | input | 1 | Power-down request bit written by the CPU |
| irq_pend | input | 1 | Enabled interrupt pending |
| int_tick | output | 1 | Internal clock enable (oscillator / 2) |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| sys_rst | output | 1 | Qualified internal reset |
| sfr_rst | output | 1 | One-cycle register-reset strobe |
| ram_wr_en | output | 1 | Internal RAM write permission |
| ram_keep | output | 1 | Reset came from power-down; RAM contents must be kept |

## Verification
The properties assume the following about the inputs:
- The mode requests are levels that the block samples only at ticks.
- `rst_pin` reaches the logic only through the synchroniser, so the qualification window is measured on the synchronised pin.

The stimulus keeps to these assumptions in three ways:
- It drives all inputs on the falling clock edge.
- It holds each request for exactly two oscillator cycles, so that each request covers one tick.
- It leaves a gap of at least six cycles low between reset-pin pulses, so that the qualification counter always restarts from zero.

Random pulse lengths straddle the 22/26-cycle boundary. Lengths in the band between the two limits are accepted either way.

// File: rtl/pwr_clk_ctl.sv
module pwr_clk_ctl #(
  parameter int MC_TICKS    = 6,
  parameter int RST_MC      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic pwr_on_n,
  input  logic rst_pin,
  input  logic idle_req,
  input  logic pd_req,
  input  logic irq_pend,
  output logic int_tick,
  output logic cpu_clk_en,
  output logic per_clk_en,
  output logic osc_run,
  output logic sys_rst,
  output logic sfr_rst,
  output logic ram_wr_en,
  output logic ram_keep
);
  localparam int QUAL = MC_TICKS * RST_MC;
  localparam int CW   = $clog2(QUAL + 1);
  localparam logic [CW-1:0] QMAX  = CW'(QUAL);
  localparam logic [CW-1:0] QLAST = CW'(QUAL - 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_IRST, S_PD, S_WAKE} mode_t;

  mode_t st, nxt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0] cnt;
  logic tog, pin_q, set_cond;

  assign pin_q    = sync_q[SYNC_STAGES-1];
  assign set_cond = pin_q && (cnt >= QLAST);

  always_ff @(posedge osc_clk or negedge pwr_on_n)
    if (!pwr_on_n) sync_q <= '0;
    else           sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin};

  always_ff @(posedge osc_clk or negedge pwr_on_n)
    if (!pwr_on_n)         tog <= 1'b0;
    else if (st == S_PD)   tog <= 1'b0;
    else                   tog <= ~tog;

  always_ff @(posedge osc_clk or negedge pwr_on_n)
    if (!pwr_on_n)                cnt <= '0;
    else if (!pin_q)              cnt <= '0;
    else if (tog && cnt != QMAX)  cnt <= cnt + 1'b1;

  always_ff @(posedge osc_clk or negedge pwr_on_n)
    if (!pwr_on_n) begin
      sys_rst <= 1'b0;
      sfr_rst <= 1'b0;
    end else begin
      sfr_rst <= tog && set_cond && !sys_rst;
      if (tog) sys_rst <= set_cond;
    end

  always_comb begin
    nxt = st;
    case (st)
      S_RUN:  if (!sys_rst && tog) begin
                if (pd_req)        nxt = S_PD;
                else if (idle_req) nxt = S_IDLE;
              end
      S_IDLE: if (sys_rst)               nxt = S_RUN;
              else if (pin_q)            nxt = S_IRST;
              else if (tog && irq_pend)  nxt = S_RUN;
      S_IRST: if (sys_rst)      nxt = S_RUN;
              else if (!pin_q)  nxt = S_IDLE;
      S_PD:   if (pin_q)        nxt = S_WAKE;
      S_WAKE: if (sys_rst)      nxt = S_RUN;
              else if (!pin_q)  nxt = S_PD;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge osc_clk or negedge pwr_on_n)
    if (!pwr_on_n) st <= S_RUN;
    else           st <= nxt;

  always_ff @(posedge osc_clk or negedge pwr_on_n)
    if (!pwr_on_n)                       ram_keep <= 1'b0;
    else if (st == S_RUN && nxt == S_PD) ram_keep <= 1'b1;
    else if (st == S_RUN && !sys_rst)    ram_keep <= 1'b0;

  assign int_tick   = tog;
  assign osc_run    = (st != S_PD);
  assign per_clk_en = (st == S_RUN) || (st == S_IDLE) || (st == S_IRST);
  assign cpu_clk_en = (st == S_RUN) || (st == S_IRST);
  assign ram_wr_en  = (st == S_RUN) || (st == S_IDLE);
endmodule

// File: rtl/pwr_clk_ctl_chk.sv
module pwr_clk_ctl_chk #(
  parameter int QUAL = 12
) (
  input logic osc_clk,
  input logic pwr_on_n,
  input logic pin_q,
  input logic pd_req,
  input logic irq_pend,
  input logic int_tick,
  input logic cpu_clk_en,
  input logic per_clk_en,
  input logic osc_run,
  input logic sys_rst,
  input logic sfr_rst,
  input logic ram_wr_en,
  input logic ram_keep
);
  localparam int HW = $clog2(2 * QUAL + 1);
  localparam logic [HW-1:0] HMAX = HW'(2 * QUAL);
  localparam logic [HW-1:0] HMIN = HW'(2 * QUAL - 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge osc_clk or negedge pwr_on_n)
    if (!pwr_on_n)            hi_cnt <= '0;
    else if (!pin_q)          hi_cnt <= '0;
    else if (hi_cnt != HMAX)  hi_cnt <= hi_cnt + 1'b1;

  // R2
  qual_len_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    $rose(sys_rst) |-> hi_cnt >= HMIN);
  // R3
  rel_tick_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    $fell(sys_rst) |-> ($past(int_tick) && !$past(pin_q)));
  // R6
  pd_prio_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    (int_tick && cpu_clk_en && ram_wr_en && !sys_rst && pd_req) |=> (!osc_run && !cpu_clk_en));
  // R7
  pd_hold_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    (!osc_run && !pin_q) |=> !osc_run);
  // R5
  idle_wake_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    (int_tick && per_clk_en && !cpu_clk_en && irq_pend) |=> cpu_clk_en);
  // R5
  idle_stay_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    (per_clk_en && !cpu_clk_en && !irq_pend && !pin_q && !sys_rst) |=> !cpu_clk_en);
  // R9
  sfr_in_rst_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    sfr_rst |-> sys_rst);
  // R9
  sfr_once_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    sfr_rst |=> !sfr_rst);
  // R8
  keep_stable_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    (sys_rst && $past(sys_rst)) |-> $stable(ram_keep));
  // R10
  guard_drop_chk: assert property (@(posedge osc_clk) disable iff (!pwr_on_n)
    (cpu_clk_en && !ram_wr_en && !sys_rst && !pin_q) |=> !cpu_clk_en);
endmodule

bind pwr_clk_ctl pwr_clk_ctl_chk #(.QUAL(QUAL)) u_chk (
  .osc_clk(osc_clk), .pwr_on_n(pwr_on_n), .pin_q(pin_q), .pd_req(pd_req),
  .irq_pend(irq_pend), .int_tick(int_tick), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .osc_run(osc_run), .sys_rst(sys_rst),
  .sfr_rst(sfr_rst), .ram_wr_en(ram_wr_en), .ram_keep(ram_keep)
);

// File: tb/sim_pwr_clk_ctl.sv
module sim_pwr_clk_ctl;
  logic clk = 1'b0, pwr_on_n = 1'b0, rst_pin = 1'b0;
  logic idle_req = 1'b0, pd_req = 1'b0, irq_pend = 1'b0;
  logic int_tick, cpu_clk_en, per_clk_en, osc_run, sys_rst, sfr_rst, ram_wr_en, ram_keep;

  int errs = 0, chks = 0, cyc = 0;
  int sfr_cnt = 0, rise_cnt = 0, sfr_bad = 0;
  logic prev_rst = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_clk_ctl u0 (
    .osc_clk(clk), .pwr_on_n(pwr_on_n), .rst_pin(rst_pin), .idle_req(idle_req),
    .pd_req(pd_req), .irq_pend(irq_pend), .int_tick(int_tick), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_run(osc_run), .sys_rst(sys_rst), .sfr_rst(sfr_rst),
    .ram_wr_en(ram_wr_en), .ram_keep(ram_keep)
  );

  always @(negedge clk) begin
    if (sfr_rst) sfr_cnt++;
    if (sys_rst && !prev_rst) rise_cnt++;
    if ((sys_rst && !prev_rst) != sfr_rst) sfr_bad++;
    prev_rst = sys_rst;
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, chks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      chks++; errs++;
      $display("FAIL R1 watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_qual(input int len);
    if (len <= 22) return 0;
    if (len >= 26) return 2;
    return 1;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // which: 0 idle, 1 power-down, 2 both, 3 interrupt
  task automatic req_pulse(input int which);
    @(negedge clk);
    idle_req = (which == 0 || which == 2);
    pd_req   = (which == 1 || which == 2);
    irq_pend = (which == 3);
    wait_n(2);
    idle_req = 0; pd_req = 0; irq_pend = 0;
    wait_n(2);
  endtask

  task automatic pin_pulse(input int len, output int lat, output bit held, output int rel,
                           output bit keep_at);
    @(negedge clk);
    rst_pin = 1; lat = -1; held = 1; rel = -1; keep_at = 0;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (lat < 0 && sys_rst) begin lat = i; keep_at = ram_keep; end
      if (lat >= 0 && !sys_rst) held = 0;
    end
    rst_pin = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (lat < 0 && sys_rst) begin lat = len + i; keep_at = ram_keep; end
      if (rel < 0 && !sys_rst) rel = i;
    end
    wait_n(6);
  endtask

  initial begin
    int lat, rel, r0, s0, len, e, alt, guard, op;
    bit held, kp;
    logic last_t;
    void'($urandom(32'd7741));
    wait_n(5);
    pwr_on_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cpu_clk_en && per_clk_en && osc_run && ram_wr_en, "R1 enables", {cpu_clk_en, per_clk_en, osc_run, ram_wr_en}, 15);
    check(!sys_rst && !sfr_rst && !ram_keep, "R1 resets", {sys_rst, sfr_rst, ram_keep}, 0);
    alt = 0; last_t = int_tick;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (int_tick != last_t) alt++; last_t = int_tick; end
    check(alt == 10, "R1 tick alternation", alt, 10);

    // R4 idle entry, R5 hold and exit
    req_pulse(0);
    check(!cpu_clk_en && per_clk_en && osc_run && ram_wr_en, "R4 idle enables", {cpu_clk_en, per_clk_en, osc_run, ram_wr_en}, 7);
    wait_n(20);
    check(!cpu_clk_en, "R5 idle holds", cpu_clk_en, 0);
    req_pulse(3);
    check(cpu_clk_en, "R5 irq wakes", cpu_clk_en, 1);

    // R6 both requests: power-down wins
    req_pulse(2);
    check(!osc_run && !per_clk_en && !cpu_clk_en && !ram_wr_en, "R6 power-down", {osc_run, per_clk_en, cpu_clk_en, ram_wr_en}, 0);
    alt = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (int_tick) alt++; end
    check(alt == 0, "R6 tick stopped", alt, 0);
    check(ram_keep, "R8 keep set on power-down", ram_keep, 1);

    // R7 inputs ignored in power-down; short pin returns to power-down
    req_pulse(3); req_pulse(0); req_pulse(1);
    check(!osc_run && !cpu_clk_en, "R7 irq/requests ignored", {osc_run, cpu_clk_en}, 0);
    r0 = rise_cnt;
    pin_pulse(10, lat, held, rel, kp);
    check(rise_cnt == r0 && !osc_run, "R7 short pin in power-down", rise_cnt - r0 + 2 * osc_run, 0);

    // R2 R8 R9 reset from power-down
    s0 = sfr_cnt;
    pin_pulse(40, lat, held, rel, kp);
    check(lat >= 22 && lat <= 34, "R2 power-down latency", lat, 28);
    check(kp, "R8 keep during power-down reset", kp, 1);
    check(sfr_cnt - s0 == 1, "R9 strobe count pd", sfr_cnt - s0, 1);
    check(held && rel >= 1 && rel <= 6, "R3 hold/release pd", rel, 4);
    check(cpu_clk_en && osc_run && !ram_keep, "R8 keep cleared after reset", {cpu_clk_en, osc_run, ram_keep}, 6);

    // R8 R9 reset from run
    s0 = sfr_cnt;
    pin_pulse(40, lat, held, rel, kp);
    check(lat >= 22 && lat <= 30, "R2 run latency", lat, 26);
    check(!kp, "R8 keep low for run reset", kp, 0);
    check(sfr_cnt - s0 == 1, "R9 strobe count run", sfr_cnt - s0, 1);

    // R10 reset pin during idle
    req_pulse(0);
    @(negedge clk);
    rst_pin = 1;
    wait_n(3);
    check(cpu_clk_en && !ram_wr_en, "R10 cpu resumes, ram blocked", {cpu_clk_en, ram_wr_en}, 2);
    guard = 3; kp = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sys_rst) begin kp = ram_keep; break; end
      if (!ram_wr_en) guard++;
    end
    check(guard >= 18 && guard <= 28, "R10 guard length", guard, 23);
    check(!kp, "R8 keep low for idle reset", kp, 0);
    rst_pin = 0;
    wait_n(10);
    check(cpu_clk_en && ram_wr_en, "R10 run after idle reset", {cpu_clk_en, ram_wr_en}, 3);
    req_pulse(0);
    r0 = rise_cnt;
    pin_pulse(10, lat, held, rel, kp);
    check(!cpu_clk_en && per_clk_en && rise_cnt == r0, "R10 short pin back to idle", {cpu_clk_en, per_clk_en}, 1);
    req_pulse(3);

    // random mix
    for (int it = 0; it < 60; it++) begin
      op = $urandom_range(0, 2);
      if (op == 0) begin
        len = $urandom_range(4, 44);
        e = exp_qual(len);
        pin_pulse(len, lat, held, rel, kp);
        if (e == 2) check(lat >= 0, "R2 long pulse resets", lat, 1);
        if (e == 0) check(lat < 0, "R2 short pulse ignored", lat, -1);
        if (lat >= 0 && lat <= len) begin
          check(lat >= 22 && lat <= 30 && held && rel <= 6, "R3 random timing", lat, 26);
          check(!kp, "R8 random run reset", kp, 0);
        end
      end else if (op == 1) begin
        req_pulse(0);
        wait_n($urandom_range(0, 10));
        check(!cpu_clk_en && per_clk_en, "R4 random idle", cpu_clk_en, 0);
        req_pulse(3);
        check(cpu_clk_en, "R5 random wake", cpu_clk_en, 1);
      end else begin
        req_pulse($urandom_range(1, 2));
        check(!osc_run, "R6 random power-down", osc_run, 0);
        pin_pulse(36, lat, held, rel, kp);
        check(lat >= 22 && lat <= 34 && kp, "R8 random pd reset", lat, 28);
        check(osc_run && cpu_clk_en && !ram_keep, "R8 random back to run", {osc_run, cpu_clk_en, ram_keep}, 6);
      end
    end

    check(sfr_bad == 0, "R9 strobe aligned with reset start", sfr_bad, 0);
    done = 1;
    report();
    $finish;
  end
endmodule